// File: doc/BRIEF.md
# AES-128 Encryption Round Pipeline Stage

This block is one round of a fully pipelined AES-128 encryption datapath. It takes a 128-bit state from the previous pipeline register. In the same cycle it substitutes every byte through the fixed AES S-box, rotates the rows of the state, mixes the columns in GF(2^8), and XORs in a round key. The result lands in the stage's own output register. A chain of these stages, all driven by one common advance enable, accepts a new block every cycle. A block that is stalled in the chain keeps its state and its valid flag.

Each stage owns a private round-key register. It is loaded through a write port, driven by the shared read port of a separate key-expansion unit whenever a key refresh runs. No wide bus carrying all eleven round keys has to reach every round. The parameter `FINAL_ROUND` builds the variant for the last round, which has no column mixing. The S-box is computed as the multiplicative inverse in GF(2^8) followed by the affine map, so no table has to be written out.

Top module: `aes_round_stage`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` is cleared, `out_state` becomes all zero and the local round key becomes all zero.
- R2: State bytes are column-major, and byte k sits in column k/4, row k%4. Byte 0 occupies bits [127:120], byte 1 occupies bits [119:112], and so on down to byte 15 in bits [7:0], on `in_state`, `out_state` and `key_wr_data` alike.
- R3: Every byte passes through the fixed AES S-box: multiplicative inverse modulo x^8+x^4+x^3+x+1 (zero maps to zero), then the affine map with constant 0x63. For example, 0x00 becomes 0x63 and 0x53 becomes 0xED.
- R4: After substitution, row r (r = 0..3) is rotated left by r columns. The byte in column c, row r takes the substituted byte from column (c+r) mod 4, row r, so row 0 is unchanged.
- R5: In a stage with `FINAL_ROUND`=0, each column is multiplied by the circulant matrix whose first row is [2 3 1 1]. Doubling is a left shift, then an XOR with 0x1B when the bit shifted out was 1. Tripling is doubling XOR the byte.
- R6: The local round key is XORed bitwise into the result before it is registered.
- R7: With `FINAL_ROUND`=1, column mixing is skipped. The output is substitution and row rotation, then key addition.
- R8: When `adv_en` is high at a rising edge, `out_state` takes the round result of the `in_state` presented in that cycle. A block may be presented every cycle, and each result is due one cycle after its block.
- R9: When `adv_en` is low, `out_state` and `out_valid` hold their values, and `in_state` and `in_valid` are ignored.
- R10: `out_valid` takes the value of `in_valid` at each edge where `adv_en` is high, so a bubble (`in_valid`=0) travels as an invalid slot.
- R11: When `key_wr_en` is high at an edge, the round key takes `key_wr_data`. A block that advances at that same edge still uses the previous key.
- R12: The round key loads regardless of `adv_en` and holds whenever `key_wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_en | input | 1 | Pipeline advance enable (downstream accepts) |
| in_valid | input | 1 | Valid flag of the incoming state |
| in_state | input | 128 | State from the previous pipeline register |
| key_wr_en | input | 1 | Load strobe for the local round key |
| key_wr_data | input | 128 | Round key from the key-expansion read port |
| out_valid | output | 1 | Valid flag of the registered result |
| out_state | output | 128 | Registered round result |

## Verification
Each round result is due exactly one rising edge after its block is presented with `adv_en` high. Inputs change on falling edges, and every output is sampled on the next falling edge, half a cycle after the capturing edge. A key write takes effect at its own edge, so the block presented with it is checked against the old key and the following block against the new one. During a stall the bench waits several cycles before sampling, so that a single-cycle leak of the ignored inputs shows up at the ports.

// File: rtl/aes_rnd_pkg.sv
// Package: GF(2^8) arithmetic and the computed AES S-box shared by the round stage.
// Assumes the AES reduction polynomial x^8+x^4+x^3+x+1; all functions are pure combinational.
package aes_rnd_pkg;
    localparam int          BYTE_W   = 8;
    localparam int          ROW_N    = 4;
    localparam logic [7:0]  RED_POLY = 8'h1B;
    localparam logic [7:0]  AFF_C    = 8'h63;
    localparam logic [7:0]  INV_EXP  = 8'd254;

    // Multiply by 2 in GF(2^8): shift left and reduce on carry-out.
    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? RED_POLY : 8'h00);
    endfunction

    // General GF(2^8) product by shift-and-add over the bits of b.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

    // Inverse as a^254 by square-and-multiply; zero maps to zero.
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] res;
        logic [7:0] base;
        res  = 8'h01;
        base = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (INV_EXP[i]) res = gf_mul(res, base);
            base = gf_mul(base, base);
        end
        return res;
    endfunction

    // S-box: inverse followed by the affine map.
    function automatic logic [7:0] sbox(input logic [7:0] x);
        logic [7:0] y;
        y = gf_inv(x);
        return y ^ {y[6:0], y[7]} ^ {y[5:0], y[7:6]} ^ {y[4:0], y[7:5]}
                 ^ {y[3:0], y[7:4]} ^ AFF_C;
    endfunction
endpackage

// File: rtl/aes_sub_shift.sv
// Byte substitution fused with row rotation.
// Assumes column-major byte order with byte 0 in the most significant bits;
// output byte (c,r) is the substituted input byte (c+r mod NCOL, r).
module aes_sub_shift
    import aes_rnd_pkg::*;
#(
    parameter int NCOL = 4
) (
    input  logic [NCOL*ROW_N*BYTE_W-1:0] din,
    output logic [NCOL*ROW_N*BYTE_W-1:0] dout
);
    localparam int NBYTE = NCOL * ROW_N;
    localparam int SW    = NBYTE * BYTE_W;

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        for (genvar r = 0; r < ROW_N; r++) begin : g_row
            localparam int DST = c * ROW_N + r;
            localparam int SRC = ((c + r) % NCOL) * ROW_N + r;
            // One S-box per byte, wired to its rotated position.
            assign dout[SW-1-DST*BYTE_W -: BYTE_W] = sbox(din[SW-1-SRC*BYTE_W -: BYTE_W]);
        end
    end
endmodule

// File: rtl/aes_mix_cols.sv
// Column mixing: each column times the circulant matrix with first row [2 3 1 1].
// Assumes column-major byte order with byte 0 in the most significant bits.
module aes_mix_cols
    import aes_rnd_pkg::*;
#(
    parameter int NCOL = 4
) (
    input  logic [NCOL*ROW_N*BYTE_W-1:0] din,
    output logic [NCOL*ROW_N*BYTE_W-1:0] dout
);
    localparam int NBYTE = NCOL * ROW_N;
    localparam int SW    = NBYTE * BYTE_W;

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        for (genvar r = 0; r < ROW_N; r++) begin : g_row
            localparam int I0 = c * ROW_N + r;
            localparam int I1 = c * ROW_N + (r + 1) % ROW_N;
            localparam int I2 = c * ROW_N + (r + 2) % ROW_N;
            localparam int I3 = c * ROW_N + (r + 3) % ROW_N;
            logic [BYTE_W-1:0] a0, a1, a2, a3;
            assign a0 = din[SW-1-I0*BYTE_W -: BYTE_W];
            assign a1 = din[SW-1-I1*BYTE_W -: BYTE_W];
            assign a2 = din[SW-1-I2*BYTE_W -: BYTE_W];
            assign a3 = din[SW-1-I3*BYTE_W -: BYTE_W];
            // 2*a0 + 3*a1 + a2 + a3 in GF(2^8).
            assign dout[SW-1-I0*BYTE_W -: BYTE_W] = gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3;
        end
    end
endmodule

// File: rtl/aes_round_stage.sv
// One AES-128 encryption round between pipeline registers, with a private round key.
// Assumes adv_en is the common advance of the whole pipeline; the key port is fed
// from a key-expansion read port during refresh. FINAL_ROUND drops column mixing.
module aes_round_stage
    import aes_rnd_pkg::*;
#(
    parameter bit FINAL_ROUND = 1'b0,
    parameter int NCOL        = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         adv_en,
    input  logic                         in_valid,
    input  logic [NCOL*ROW_N*BYTE_W-1:0] in_state,
    input  logic                         key_wr_en,
    input  logic [NCOL*ROW_N*BYTE_W-1:0] key_wr_data,
    output logic                         out_valid,
    output logic [NCOL*ROW_N*BYTE_W-1:0] out_state
);
    localparam int SW = NCOL * ROW_N * BYTE_W;

    logic [SW-1:0] round_key;
    logic [SW-1:0] shifted;
    logic [SW-1:0] mixed;
    logic [SW-1:0] next_state;

    aes_sub_shift #(.NCOL(NCOL)) u_sub_shift (
        .din  (in_state),
        .dout (shifted)
    );

    if (FINAL_ROUND) begin : g_last
        // Last round: no column mixing.
        assign mixed = shifted;
    end else begin : g_mid
        aes_mix_cols #(.NCOL(NCOL)) u_mix (
            .din  (shifted),
            .dout (mixed)
        );
    end

    // Round-key addition.
    assign next_state = mixed ^ round_key;

    // Local round-key register, refreshed through the write port.
    always_ff @(posedge clk) begin
        if (!rst_n)         round_key <= '0;
        else if (key_wr_en) round_key <= key_wr_data;
    end

    // Output pipeline register with its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_state <= '0;
        end else if (adv_en) begin
            out_valid <= in_valid;
            out_state <= next_state;
        end
    end
endmodule

// File: rtl/aes_round_stage_chk.sv
// Checker for aes_round_stage: pipeline advance, hold and key-register rules.
// Assumes it is bound into the stage and sees its private round key.
module aes_round_stage_chk #(
    parameter int SW = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adv_en,
    input logic          in_valid,
    input logic          key_wr_en,
    input logic [SW-1:0] key_wr_data,
    input logic          out_valid,
    input logic [SW-1:0] out_state,
    input logic [SW-1:0] round_key
);
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!out_valid && out_state == '0 && round_key == '0));

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |=> (out_valid == $past(in_valid)));

    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_en |=> ($stable(out_valid) && $stable(out_state)));

    a_r11_key_load: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr_en |=> (round_key == $past(key_wr_data)));

    a_r12_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr_en |=> $stable(round_key));
endmodule

bind aes_round_stage aes_round_stage_chk #(.SW(SW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv_en      (adv_en),
    .in_valid    (in_valid),
    .key_wr_en   (key_wr_en),
    .key_wr_data (key_wr_data),
    .out_valid   (out_valid),
    .out_state   (out_state),
    .round_key   (round_key)
);

// File: tb/tb_aes_round_stage.sv
// Directed bench: a middle-round stage (dut) and a final-round stage (dut_last)
// share all inputs; results are compared with a bench-side reference model.
module tb_aes_round_stage;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         adv_en = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_state = '0;
    logic         key_wr_en = 1'b0;
    logic [127:0] key_wr_data = '0;
    logic         out_valid, last_valid;
    logic [127:0] out_state, last_state;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    aes_round_stage #(.FINAL_ROUND(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .in_valid(in_valid),
        .in_state(in_state), .key_wr_en(key_wr_en), .key_wr_data(key_wr_data),
        .out_valid(out_valid), .out_state(out_state));

    aes_round_stage #(.FINAL_ROUND(1'b1)) dut_last (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .in_valid(in_valid),
        .in_state(in_state), .key_wr_en(key_wr_en), .key_wr_data(key_wr_data),
        .out_valid(last_valid), .out_state(last_state));

    // ---------------- reference model ----------------
    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= a;
            a = a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
        end
        return p;
    endfunction

    function automatic logic [7:0] m_sbox(input logic [7:0] x);
        logic [7:0] y = 8'h00;
        logic [7:0] s;
        for (int c = 1; c < 256; c++)
            if (x != 8'h00 && m_mul(x, 8'(c)) == 8'h01) y = 8'(c);
        s = 8'h63;
        for (int k = 0; k < 5; k++) s ^= (y << k) | (y >> (8 - k));
        return s;
    endfunction

    function automatic logic [127:0] m_round(input logic [127:0] s, input logic [127:0] k,
                                             input bit fin);
        logic [7:0] a [16];
        logic [7:0] b [16];
        logic [7:0] m [16];
        logic [7:0] coef [4];
        logic [127:0] res;
        coef[0] = 8'h02; coef[1] = 8'h03; coef[2] = 8'h01; coef[3] = 8'h01;
        for (int i = 0; i < 16; i++) a[i] = m_sbox(s[127-8*i -: 8]);
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) b[4*c+r] = a[4*((c+r)%4)+r];
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) begin
                m[4*c+r] = 8'h00;
                for (int j = 0; j < 4; j++)
                    m[4*c+r] ^= m_mul(coef[(j-r+4)%4], b[4*c+j]);
            end
        for (int i = 0; i < 16; i++) res[127-8*i -: 8] = fin ? b[i] : m[i];
        return res ^ k;
    endfunction

    // ---------------- check helpers ----------------
    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input logic v, input logic [127:0] s);
        in_valid = v;
        in_state = s;
        adv_en   = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_key(input logic [127:0] k);
        key_wr_en   = 1'b1;
        key_wr_data = k;
        adv_en      = 1'b0;
        @(negedge clk);
        key_wr_en   = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        chk("R1 out_valid", {127'd0, out_valid}, 128'd0);
        chk("R1 out_state", out_state, 128'd0);
        push(1'b1, 128'd0);  // zero key: zero state gives all 0x63
        chk("R1 zero key mid", out_state, {16{8'h63}});
        chk("R1 zero key last", last_state, {16{8'h63}});
    endtask

    task automatic t_byte_order;
        push(1'b1, {8'h53, 120'd0});
        chk("R2 byte0 msb", last_state, {8'hED, {15{8'h63}}});
        chk("R3 sbox 53", {120'd0, last_state[127:120]}, 128'hED);
    endtask

    task automatic t_rows;
        for (int k = 0; k < 16; k++) begin
            logic [127:0] s = '0;
            s[127-8*k -: 8] = 8'(8'h11 * (k + 1));
            push(1'b1, s);
            chk("R4 rotate", last_state, m_round(s, '0, 1'b1));
            chk("R5 mix", out_state, m_round(s, '0, 1'b0));
        end
    endtask

    task automatic t_known;
        load_key(128'ha0fafe1788542cb123a339392a6c7605);
        push(1'b1, 128'h193de3bea0f4e22b9ac68d2ae9f84808);
        chk("R6 known mid round", out_state, 128'ha49c7ff2689f352b6b5bea43026a5049);
        load_key(128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
        push(1'b1, 128'heb40f21e592e38848ba113e71bc342d2);
        chk("R7 known final round", last_state, 128'h3925841d02dc09fbdc118597196a0b32);
    endtask

    task automatic t_stream;
        logic [127:0] k = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
        load_key(k);
        for (int i = 0; i < 6; i++) begin
            logic [127:0] s = {4{32'h9e3779b9 * (i + 3)}} ^ {i[7:0], 120'h80};
            push(1'b1, s);
            chk("R8 stream mid", out_state, m_round(s, k, 1'b0));
            chk("R8 stream last", last_state, m_round(s, k, 1'b1));
            chk("R10 valid", {127'd0, out_valid}, 128'd1);
        end
    endtask

    task automatic t_bubble;
        push(1'b0, 128'h1234);
        chk("R10 bubble", {127'd0, out_valid}, 128'd0);
        push(1'b1, 128'h5678);
        chk("R10 valid again", {127'd0, out_valid}, 128'd1);
    endtask

    task automatic t_stall;
        logic [127:0] held;
        logic [127:0] k = 128'h00112233445566778899aabbccddeeff;
        logic [127:0] s = 128'hdeadbeef0badf00dcafe1234feedface;
        load_key(k);
        push(1'b1, s);
        held = m_round(s, k, 1'b0);
        adv_en   = 1'b0;
        in_valid = 1'b0;
        in_state = ~s;
        repeat (3) @(negedge clk);
        chk("R9 hold state", out_state, held);
        chk("R9 hold valid", {127'd0, out_valid}, 128'd1);
        // R12: key loads while stalled, and is used by the next block.
        key_wr_en   = 1'b1;
        key_wr_data = ~k;
        @(negedge clk);
        key_wr_en = 1'b0;
        chk("R12 stalled write holds out", out_state, held);
        push(1'b1, s);
        chk("R12 key loaded while stalled", out_state, m_round(s, ~k, 1'b0));
    endtask

    task automatic t_key_edge;
        logic [127:0] k1 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
        logic [127:0] k2 = 128'h3c4fcf098815f7aba6d2ae2816157e2b;
        logic [127:0] s  = 128'h3243f6a8885a308d313198a2e0370734;
        load_key(k1);
        key_wr_en   = 1'b1;
        key_wr_data = k2;
        push(1'b1, s);
        key_wr_en = 1'b0;
        chk("R11 same edge old key", out_state, m_round(s, k1, 1'b0));
        push(1'b1, s);
        chk("R11 next block new key", out_state, m_round(s, k2, 1'b0));
        push(1'b1, s ^ 128'h1);
        chk("R12 key held", out_state, m_round(s ^ 128'h1, k2, 1'b0));
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog actual %0d cycles expected at most 20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_byte_order();
        t_rows();
        t_known();
        t_stream();
        t_bubble();
        t_stall();
        t_key_edge();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule